// File: doc/BRIEF.md
# Programmable-Length Serial Shift Register

This block is a serial shift register whose effective length can be chosen while it runs, anywhere from 1 to 64 bits. A six-bit length code holds the binary value of the length minus one. The bit stored at the stage with that number appears on a true output and on a complemented output. A select line picks one of two serial inputs for the first stage. With one input tied to the block's own output, the register recirculates its contents; the other input loads fresh data.

The two shift inputs behave like a slow clock and a clock enable, but the block is fully synchronous to a fast system clock. Both inputs pass through synchronizers. A shift is taken on either of two edge patterns found in their sampled history: a rising shift clock while the enable is low, or a falling enable while the shift clock is high. A master reset clears every stage as soon as it is asserted, and its release is aligned to the system clock.

Top module: `varlen_shreg`

## Requirements
- R1: With length code `len_code` = k, a bit entering stage 1 reaches the output after exactly k+1 shifts, so the output shows stage k+1 (stage 1 is the entry stage).
- R2: Code 0 gives a 1-bit register, where the output follows the most recent input bit. Code 63 gives a 64-bit register, where a bit appears on the 64th shift and not on the 63rd.
- R3: `sel_b` = 0 feeds `din_a` into stage 1 and `sel_b` = 1 feeds `din_b`. The unselected input has no effect.
- R4: A rising edge on `shift_clk` while `shift_en` is low causes one shift. A rising edge on `shift_clk` while `shift_en` is high causes none.
- R5: A falling edge on `shift_en` while `shift_clk` is high causes one shift. A falling edge on `shift_en` while `shift_clk` is low causes none.
- R6: On each shift every stored bit moves one stage toward the output. A change of `len_code` changes the output combinationally, without altering any stored bit.
- R7: While `rst_in` is high, the output `q` is 0 and `q_n` is 1 at once, without waiting for a clock edge, all stages are cleared, and shift edges are ignored.
- R8: `q_n` is always the complement of `q`.
- R9: A qualifying input transition made between system clock edges takes effect at the third following rising edge of `clk`.
- R10: A qualifying edge that would take effect in the first system clock cycle after the internal reset releases is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all inputs |
| rst_in | input | 1 | Master reset, active high. It asserts asynchronously and releases synchronously |
| din_a | input | 1 | Serial data input chosen when `sel_b` is 0 |
| din_b | input | 1 | Serial data input chosen when `sel_b` is 1 |
| sel_b | input | 1 | Serial input select |
| shift_clk | input | 1 | Clock-style shift input (asynchronous) |
| shift_en | input | 1 | Enable-style shift input (asynchronous) |
| len_code | input | 6 | Register length minus one |
| q | output | 1 | Bit held at stage `len_code`+1 |
| q_n | output | 1 | Complement of `q` |

## Verification
A change on `shift_clk` or `shift_en` made at a falling clock edge crosses two synchronizer flops. The shift it triggers then lands on the third rising edge of `clk`. Every bench phase therefore holds its inputs for four cycles and samples at a falling edge after that. The latency check samples after the second rising edge, where the old value is expected, and again after the third, where the new value is expected. Tap selection and reset are combinational or asynchronous paths to the output, so those checks sample one nanosecond after the input changes, before any clock edge. Every shift is mirrored in a reference array in the bench, and the whole register is read out by sweeping `len_code` over all 64 taps.

// File: rtl/vls_pkg.sv
`timescale 1ns/1ps
package vls_pkg;
   parameter int unsigned VLS_MAX_LEN    = 64;
   parameter int unsigned VLS_SYNC_DEPTH = 2;

   typedef enum logic [1:0] {
      TRIG_NONE     = 2'd0,
      TRIG_CLK_RISE = 2'd1,
      TRIG_EN_FALL  = 2'd2
   } vls_trig_e;
endpackage

// File: rtl/vls_rst_sync.sv
`timescale 1ns/1ps
module vls_rst_sync #(
   parameter int unsigned DEPTH = 2
) (
   input  logic clk,
   input  logic rst_async,
   output logic rst_sync
);
   logic [DEPTH-1:0] chain;

   always_ff @(posedge clk or posedge rst_async) begin
      if (rst_async) chain <= '1;
      else           chain <= {chain[DEPTH-2:0], 1'b0};
   end

   assign rst_sync = chain[DEPTH-1];
endmodule

// File: rtl/vls_sync.sv
`timescale 1ns/1ps
module vls_sync #(
   parameter int unsigned DEPTH = 2,
   parameter int unsigned WIDTH = 2
) (
   input  logic             clk,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] stage_q [DEPTH];

   generate
      for (genvar s = 0; s < DEPTH; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk) stage_q[0] <= d;
         end else begin : g_next
            always_ff @(posedge clk) stage_q[s] <= stage_q[s-1];
         end
      end
   endgenerate

   assign q = stage_q[DEPTH-1];
endmodule

// File: rtl/vls_edge_qual.sv
`timescale 1ns/1ps
module vls_edge_qual
   import vls_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic ck_s,
   input  logic en_s,
   output logic fire
);
   logic      ck_d;
   logic      en_d;
   logic      armed;
   vls_trig_e kind;

   // history keeps sampling during reset so it is valid at release
   always_ff @(posedge clk) begin
      ck_d <= ck_s;
      en_d <= en_s;
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst) armed <= 1'b0;
      else     armed <= 1'b1;
   end

   always_comb begin
      kind = TRIG_NONE;
      if (ck_s && !ck_d && !en_s)      kind = TRIG_CLK_RISE;
      else if (!en_s && en_d && ck_s)  kind = TRIG_EN_FALL;
   end

   assign fire = armed && !rst && (kind != TRIG_NONE);
endmodule

// File: rtl/vls_stages.sv
`timescale 1ns/1ps
module vls_stages #(
   parameter int unsigned N = 64
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         shift,
   input  logic         din,
   output logic [N-1:0] stages
);
   generate
      for (genvar g = 0; g < N; g++) begin : g_cell
         if (g == 0) begin : g_head
            always_ff @(posedge clk or posedge rst) begin
               if (rst)        stages[0] <= 1'b0;
               else if (shift) stages[0] <= din;
            end
         end else begin : g_body
            always_ff @(posedge clk or posedge rst) begin
               if (rst)        stages[g] <= 1'b0;
               else if (shift) stages[g] <= stages[g-1];
            end
         end
      end
   endgenerate
endmodule

// File: rtl/vls_tap.sv
`timescale 1ns/1ps
module vls_tap #(
   parameter int unsigned N = 64,
   parameter int unsigned W = 6
) (
   input  logic [N-1:0] stages,
   input  logic [W-1:0] code,
   output logic         q,
   output logic         q_n
);
   assign q   = stages[code];
   assign q_n = ~q;
endmodule

// File: rtl/varlen_shreg.sv
`timescale 1ns/1ps
module varlen_shreg #(
   parameter int unsigned MAX_LEN    = vls_pkg::VLS_MAX_LEN,
   parameter int unsigned SYNC_DEPTH = vls_pkg::VLS_SYNC_DEPTH,
   localparam int unsigned SEL_W     = $clog2(MAX_LEN)
) (
   input  logic             clk,
   input  logic             rst_in,
   input  logic             din_a,
   input  logic             din_b,
   input  logic             sel_b,
   input  logic             shift_clk,
   input  logic             shift_en,
   input  logic [SEL_W-1:0] len_code,
   output logic             q,
   output logic             q_n
);
   generate
      if (MAX_LEN < 2 || (1 << SEL_W) != MAX_LEN) begin : g_bad_len
         $error("MAX_LEN must be a power of two of at least 2");
      end
      if (SYNC_DEPTH < 2) begin : g_bad_sync
         $error("SYNC_DEPTH must be at least 2");
      end
   endgenerate

   logic               rst_int;
   logic [1:0]         trig_s;
   logic               fire;
   logic               entry_bit;
   logic [MAX_LEN-1:0] stages;

   vls_rst_sync #(.DEPTH(SYNC_DEPTH)) u_rst (
      .clk(clk), .rst_async(rst_in), .rst_sync(rst_int)
   );

   vls_sync #(.DEPTH(SYNC_DEPTH), .WIDTH(2)) u_sync (
      .clk(clk), .d({shift_en, shift_clk}), .q(trig_s)
   );

   vls_edge_qual u_qual (
      .clk(clk), .rst(rst_int), .ck_s(trig_s[0]), .en_s(trig_s[1]), .fire(fire)
   );

   assign entry_bit = sel_b ? din_b : din_a;

   vls_stages #(.N(MAX_LEN)) u_stages (
      .clk(clk), .rst(rst_int), .shift(fire), .din(entry_bit), .stages(stages)
   );

   vls_tap #(.N(MAX_LEN), .W(SEL_W)) u_tap (
      .stages(stages), .code(len_code), .q(q), .q_n(q_n)
   );
endmodule

// File: rtl/vls_chk.sv
`timescale 1ns/1ps
module vls_chk #(
   parameter int unsigned MAX_LEN = 64
) (
   input logic               clk,
   input logic               rst_in,
   input logic               rst_int,
   input logic               fire,
   input logic               din_a,
   input logic               din_b,
   input logic               sel_b,
   input logic [MAX_LEN-1:0] stages,
   input logic               q,
   input logic               q_n
);
   // R7
   rst_out_chk: assert property (@(posedge clk)
      rst_in |-> (q == 1'b0 && q_n == 1'b1 && stages == '0));

   // R6
   shift_move_chk: assert property (@(posedge clk) disable iff (rst_int)
      fire |=> stages[MAX_LEN-1:1] == $past(stages[MAX_LEN-2:0]));

   // R3
   entry_sel_chk: assert property (@(posedge clk) disable iff (rst_int)
      fire |=> stages[0] == $past(sel_b ? din_b : din_a));

   // R4
   no_trig_hold_chk: assert property (@(posedge clk) disable iff (rst_int)
      !fire |=> $stable(stages));

   // R10
   release_ignore_chk: assert property (@(posedge clk) disable iff (rst_in)
      $fell(rst_int) |-> !fire);
endmodule

bind varlen_shreg vls_chk #(.MAX_LEN(MAX_LEN)) u_chk (
   .clk(clk), .rst_in(rst_in), .rst_int(rst_int), .fire(fire),
   .din_a(din_a), .din_b(din_b), .sel_b(sel_b),
   .stages(stages), .q(q), .q_n(q_n)
);

// File: tb/varlen_shreg_bench.sv
`timescale 1ns/1ps
module varlen_shreg_bench;
   localparam int NL = 64;

   logic       clk = 1'b0;
   logic       rst_in = 1'b1;
   logic       din_a = 1'b0, din_b = 1'b0, sel_b = 1'b0;
   logic       shift_clk = 1'b0, shift_en = 1'b0;
   logic [5:0] len_code = 6'd0;
   logic       q, q_n;

   int  n_run = 0;
   int  n_fail = 0;
   logic mdl [NL];

   always #10 clk = ~clk;

   varlen_shreg u_varlen_shreg (
      .clk(clk), .rst_in(rst_in), .din_a(din_a), .din_b(din_b), .sel_b(sel_b),
      .shift_clk(shift_clk), .shift_en(shift_en), .len_code(len_code),
      .q(q), .q_n(q_n)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %b expected %b", req, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic mdl_shift(input logic d);
      for (int i = NL-1; i > 0; i--) mdl[i] = mdl[i-1];
      mdl[0] = d;
   endtask

   task automatic mdl_clear();
      for (int i = 0; i < NL; i++) mdl[i] = 1'b0;
   endtask

   task automatic set_data(input logic d, input logic s);
      sel_b = s;
      din_a = s ? ~d : d;
      din_b = s ? d : ~d;
   endtask

   // rising shift_clk with shift_en low
   task automatic pulse_a(input logic d, input logic s);
      set_data(d, s);
      shift_clk = 1'b1; wait_cyc(4);
      shift_clk = 1'b0; wait_cyc(4);
      mdl_shift(d);
   endtask

   // falling shift_en with shift_clk high
   task automatic pulse_b(input logic d, input logic s);
      set_data(d, s);
      shift_en = 1'b1;  wait_cyc(4);
      shift_clk = 1'b1; wait_cyc(4);
      shift_en = 1'b0;  wait_cyc(4);
      shift_clk = 1'b0; wait_cyc(4);
      mdl_shift(d);
   endtask

   task automatic scan_all(input string req);
      for (int i = 0; i < NL; i++) begin
         len_code = 6'(i); #1;
         chk(req, q, mdl[i]);
         chk("R8", q_n, ~mdl[i]);
      end
   endtask

   task automatic t_reset_state();
      mdl_clear();
      wait_cyc(3);
      len_code = 6'd0;  #1; chk("R7", q, 1'b0); chk("R8", q_n, 1'b1);
      len_code = 6'd63; #1; chk("R7", q, 1'b0); chk("R8", q_n, 1'b1);
      rst_in = 1'b0; wait_cyc(4);
   endtask

   task automatic t_extremes();
      len_code = 6'd0;
      pulse_a(1'b1, 1'b0); chk("R2", q, 1'b1);
      pulse_a(1'b0, 1'b1); chk("R2", q, 1'b0);
      len_code = 6'd63;
      pulse_a(1'b1, 1'b0);
      for (int i = 0; i < 62; i++) pulse_a(1'b0, 1'b0);
      chk("R2", q, 1'b0);
      pulse_b(1'b0, 1'b1);
      chk("R2", q, 1'b1);
      chk("R1", q, mdl[63]);
   endtask

   task automatic t_random();
      for (int it = 0; it < 150; it++) begin
         logic d, s, f;
         d = 1'($urandom); s = 1'($urandom); f = 1'($urandom);
         if (f) pulse_b(d, s); else pulse_a(d, s);
         len_code = 6'($urandom % NL); #1;
         chk("R1", q, mdl[len_code]);
         chk("R3", q_n, ~mdl[len_code]);
      end
      scan_all("R6");
   endtask

   task automatic t_no_shift();
      set_data(1'b1, 1'b0);
      shift_en = 1'b1;  wait_cyc(4);
      shift_clk = 1'b1; wait_cyc(4);
      shift_clk = 1'b0; wait_cyc(4);
      scan_all("R4");
      set_data(1'b0, 1'b1);
      shift_en = 1'b0;  wait_cyc(4);
      scan_all("R5");
   endtask

   task automatic t_latency();
      logic old_v;
      len_code = 6'd0; #1;
      old_v = mdl[0];
      set_data(~old_v, 1'b0);
      shift_clk = 1'b1;
      @(posedge clk); @(posedge clk); @(negedge clk);
      chk("R9", q, old_v);
      @(posedge clk); @(negedge clk);
      chk("R9", q, ~old_v);
      mdl_shift(~old_v);
      shift_clk = 1'b0; wait_cyc(4);
   endtask

   task automatic t_async_reset();
      pulse_a(1'b1, 1'b0);
      len_code = 6'd0; #1;
      chk("R7", q, 1'b1);
      @(negedge clk); #3;
      rst_in = 1'b1; #1;
      chk("R7", q, 1'b0); chk("R8", q_n, 1'b1);
      mdl_clear();
      wait_cyc(1);
      set_data(1'b1, 1'b0);
      shift_clk = 1'b1; wait_cyc(4);
      shift_clk = 1'b0; wait_cyc(4);
      chk("R7", q, 1'b0);
   endtask

   task automatic t_release();
      len_code = 6'd0;
      set_data(1'b1, 1'b0);
      rst_in = 1'b0;
      shift_clk = 1'b1;
      wait_cyc(6);
      chk("R10", q, 1'b0);
      shift_clk = 1'b0; wait_cyc(4);
      pulse_a(1'b1, 1'b0);
      chk("R10", q, 1'b1);
      scan_all("R1");
   endtask

   initial begin
      t_reset_state();
      t_extremes();
      t_random();
      t_no_shift();
      t_latency();
      t_async_reset();
      t_release();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 20);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule